// File: doc/BRIEF.md
# Serial Port Register Bank and Interrupt Combiner

This block is the register front end of a serial port. It decodes a 4 KB address window and holds the port's settings: the baud divisors, line control, control, FIFO level select, DMA control, and the interrupt mask. It keeps a raw interrupt status word, shows its masked view, and drives one level-sensitive interrupt line from it. The receive FIFO, the bit-level shifter and the DMA engine lie outside the block.

A write to the data word hands the low byte to the transmit side as a one-cycle strobe and raises the transmit interrupt. An external pulse raises the receive interrupt. Software clears either interrupt by writing ones to the clear word. Each register sits at address bits [11:2]. Reads return data one cycle after the request. Any access to an address that decodes to nothing pulses an error output.

Top module: `uart_regbank`

## Requirements
- R1: After reset, control reads 0x300, FIFO level select reads 0x12, flags read 0x90, raw status and mask read 0, and `irq` is low.
- R2: `irq` is high exactly when raw status AND mask is nonzero, from the cycle after the mask or status changes. Masked status (word 16) reads that AND. Writing a mask of zero drops `irq` on the next cycle.
- R3: A write to word 0 pulses `tx_strobe` for one cycle, starting the cycle after the request, with `tx_byte` equal to write data [7:0]. It also sets raw status bit 5 (transmit).
- R4: A pulse on `rx_event` sets raw status bit 4 (receive). If it arrives in the same cycle as a clear of bit 4, the set wins.
- R5: A write to word 17 clears each raw status bit whose written bit is 1 and leaves the others unchanged.
- R6: The writable words keep only their low bits and read back with upper bits zero:
  - word 8: 8 bits
  - word 9: 16 bits
  - word 10: 6 bits
  - word 11: 8 bits
  - word 12: 16 bits
  - word 13: 6 bits
  - word 14 (mask): 11 bits
  - word 18: 3 bits
- R7: Writes to the flags word (6) and to the ID area (words 0x3F8–0x3FF) are ignored. ID words 0x3F8 through 0x3FF read the bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R8: An access to an unmapped word reads 0 and changes no state. It raises `bad_access` for one cycle, in the cycle after the request. A mapped access never raises `bad_access`. Mapped words are 0, 1, 6, 8 to 18, and 0x3F8 to 0x3FF.
- R9: A read request raises `rd_valid` for one cycle in the next cycle, with `rd_data` holding the word.
- R10: Word 1 (receive status / error clear) accepts writes without error and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [11:2] select the word |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| bad_access | output | 1 | One-cycle pulse for an access to an unmapped word |
| rx_event | input | 1 | Pulse that raises the receive interrupt |
| tx_strobe | output | 1 | One-cycle pulse for a data-word write |
| tx_byte | output | 8 | Byte written to the data word |
| irq | output | 1 | Level interrupt, OR of the masked status bits |

## Verification
Four kinds of result are due one clock edge after the request that causes them:
- read data with `rd_valid`
- `tx_strobe` and `tx_byte`
- `bad_access`
- the new `irq` level after a mask, clear, data or `rx_event` change

The bench drives each request on a falling edge and checks it on the next falling edge, after exactly one rising edge. A driver task queues the expected read word and a monitor compares it when `rd_valid` appears. Strobe, error and interrupt levels are checked directly right after the request's edge, before the next request is driven.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int IRQ_W = 11,
  parameter logic [63:0] PERIPH_ID = 64'hB105_F00D_0014_1011,
  parameter logic [15:0] CTRL_RST = 16'h0300,
  parameter logic [5:0]  FLS_RST  = 6'h12,
  parameter logic [7:0]  FLAGS_VAL = 8'h90
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        bad_access,
  input  logic        rx_event,
  output logic        tx_strobe,
  output logic [7:0]  tx_byte,
  output logic        irq
);
  localparam int RX_BIT = 4;
  localparam int TX_BIT = 5;

  logic [9:0] idx;
  logic       is_id, mapped, wr, rd;
  logic [7:0]  ilp_q, lcr_q;
  logic [15:0] ibd_q, ctl_q;
  logic [5:0]  fbd_q, fls_q;
  logic [2:0]  dma_q;
  logic [IRQ_W-1:0] msk_q, ris_q, ris_set, ris_clr;
  logic [31:0] rd_mux;

  assign idx   = bus_addr[11:2];
  assign is_id = idx >= 10'h3F8;
  assign mapped = is_id || idx == 10'd0 || idx == 10'd1 || idx == 10'd6 ||
                  (idx >= 10'd8 && idx <= 10'd18);
  assign wr = bus_valid && bus_write && mapped;
  assign rd = bus_valid && !bus_write;

  assign irq = |(ris_q & msk_q);

  always_comb begin
    ris_set = '0;
    ris_set[RX_BIT] = rx_event;
    ris_set[TX_BIT] = wr && idx == 10'd0;
    ris_clr = (wr && idx == 10'd17) ? bus_wdata[IRQ_W-1:0] : '0;
  end

  always_comb begin
    rd_mux = '0;
    if (is_id) rd_mux = {24'd0, PERIPH_ID[idx[2:0]*8 +: 8]};
    else begin
      case (idx)
        10'd6:  rd_mux = {24'd0, FLAGS_VAL};
        10'd8:  rd_mux = {24'd0, ilp_q};
        10'd9:  rd_mux = {16'd0, ibd_q};
        10'd10: rd_mux = {26'd0, fbd_q};
        10'd11: rd_mux = {24'd0, lcr_q};
        10'd12: rd_mux = {16'd0, ctl_q};
        10'd13: rd_mux = {26'd0, fls_q};
        10'd14: rd_mux = {{(32-IRQ_W){1'b0}}, msk_q};
        10'd15: rd_mux = {{(32-IRQ_W){1'b0}}, ris_q};
        10'd16: rd_mux = {{(32-IRQ_W){1'b0}}, ris_q & msk_q};
        10'd18: rd_mux = {29'd0, dma_q};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ilp_q <= '0; lcr_q <= '0; ibd_q <= '0; fbd_q <= '0; dma_q <= '0;
      ctl_q <= CTRL_RST; fls_q <= FLS_RST;
      msk_q <= '0; ris_q <= '0;
      rd_data <= '0; rd_valid <= 1'b0; bad_access <= 1'b0;
      tx_strobe <= 1'b0; tx_byte <= '0;
    end else begin
      ris_q <= (ris_q & ~ris_clr) | ris_set;
      rd_valid   <= rd;
      rd_data    <= rd ? rd_mux : '0;
      bad_access <= bus_valid && !mapped;
      tx_strobe  <= wr && idx == 10'd0;
      if (wr) begin
        case (idx)
          10'd0:  tx_byte <= bus_wdata[7:0];
          10'd8:  ilp_q <= bus_wdata[7:0];
          10'd9:  ibd_q <= bus_wdata[15:0];
          10'd10: fbd_q <= bus_wdata[5:0];
          10'd11: lcr_q <= bus_wdata[7:0];
          10'd12: ctl_q <= bus_wdata[15:0];
          10'd13: fls_q <= bus_wdata[5:0];
          10'd14: msk_q <= bus_wdata[IRQ_W-1:0];
          10'd18: dma_q <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  assert_tx_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && idx == 10'd0) |=>
      (tx_strobe && tx_byte == $past(bus_wdata[7:0]) && ris_q[TX_BIT]));
  assert_rx_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> ris_q[RX_BIT]);
  assert_clear_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && idx == 10'd17 && bus_wdata[TX_BIT]) |=> !ris_q[TX_BIT]);
  assert_mask_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && idx == 10'd14 && bus_wdata[IRQ_W-1:0] == '0) |=> !irq);
  assert_bad_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !bad_access);
  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);
endmodule

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, rx_event = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic rd_valid, bad_access, tx_strobe, irq;
  logic [7:0] tx_byte;
  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank uut (.clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata,
    .rd_data, .rd_valid, .bad_access, .rx_event, .tx_strobe, .tx_byte, .irq);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(bit w, int word, logic [31:0] d, bit rx);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = 12'(word << 2); bus_wdata = d; rx_event = rx;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; rx_event = 0;
  endtask

  task automatic wr(int word, logic [31:0] d); op(1, word, d, 0); endtask

  task automatic rd(int word, logic [31:0] exp, string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    op(0, word, 0, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (exp_q.size() != 0) check("R9 missing read", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq", irq, 0);
    rd(12, 32'h300, "R1 control");
    rd(13, 32'h12, "R1 level select");
    rd(6, 32'h90, "R1 flags");
    rd(15, 0, "R1 raw status");
    rd(14, 0, "R1 mask");

    wr(9, 32'hFFFF_FFFF);  rd(9, 32'hFFFF, "R6 word9");
    wr(10, 32'hFF);        rd(10, 32'h3F, "R6 word10");
    wr(8, 32'h1AB);        rd(8, 32'hAB, "R6 word8");
    wr(11, 32'h1FF);       rd(11, 32'hFF, "R6 word11");
    wr(12, 32'h1_2345);    rd(12, 32'h2345, "R6 word12");
    wr(13, 32'hFF);        rd(13, 32'h3F, "R6 word13");
    wr(18, 32'hF);         rd(18, 32'h7, "R6 word18");
    wr(14, 32'hFFFF);      rd(14, 32'h7FF, "R6 mask");
    wr(14, 0);             check("R2 zero mask irq", irq, 0);

    wr(6, 0);              rd(6, 32'h90, "R7 flags write ignored");
    wr(32'h3F8, 32'h55);   rd(32'h3F8, 32'h11, "R7 id0 after write");
    rd(32'h3FC, 32'h0D, "R7 id4");
    rd(32'h3FF, 32'hB1, "R7 id7");

    wr(2, 32'hDEAD);       check("R8 bad write pulse", bad_access, 1);
    @(negedge clk);        check("R8 pulse one cycle", bad_access, 0);
    rd(2, 0, "R8 unmapped read");
    check("R8 bad read pulse", bad_access, 1);
    rd(32'h100, 0, "R8 unmapped high");
    wr(1, 5);              check("R10 no error", bad_access, 0);
    rd(1, 0, "R10 reads zero");
    check("R8 mapped no error", bad_access, 0);

    wr(0, 32'h1A5);
    check("R3 strobe", tx_strobe, 1);
    check("R3 byte", tx_byte, 8'hA5);
    check("R2 masked irq low", irq, 0);
    rd(15, 32'h20, "R3 tx raw bit");
    check("R3 strobe one cycle", tx_strobe, 0);
    rd(16, 0, "R2 masked status zero");
    wr(14, 32'h20);        check("R2 irq after mask", irq, 1);
    rd(16, 32'h20, "R2 masked status");

    wr(17, 32'h10);        rd(15, 32'h20, "R5 unrelated bit kept");
    check("R5 irq kept", irq, 1);
    wr(17, 32'h20);        rd(15, 0, "R5 cleared");
    check("R5 irq dropped", irq, 0);

    op(0, 7, 0, 1);
    exp_q.push_back(0); tag_q.push_back("R8 read with rx");
    rd(15, 32'h10, "R4 rx raw bit");
    wr(14, 32'h10);        check("R4 irq on rx", irq, 1);
    op(1, 17, 32'h10, 1);  rd(15, 32'h10, "R4 set beats clear");
    wr(17, 32'h30);        rd(15, 0, "R5 clear both");
    check("R2 irq low at end", irq, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule